// File: doc/BRIEF.md
# I2C Target with Bus Timeout

This block is the serial front end of a small register-mapped peripheral that sits on a two-wire I2C bus as a target. It samples SCL and SDA with the system clock and recognises START, repeated START and STOP. It compares the first byte of each transfer against a fixed 7-bit device address. On a match it acknowledges, then either takes bytes in from the controller or shifts bytes out to it. SDA is driven open-drain: the block only ever pulls the line low, through an output-enable.

On the core side the block exposes a byte-wide register port. In a write transfer, the first data byte sets an 8-bit pointer. Every later byte is offered on the write-data output with a one-cycle strobe and then advances the pointer. A read transfer shifts out the byte presented on the read-data input for the current pointer, and the pointer advances after each byte.

A watchdog counts system clock cycles from the most recent START. If no STOP arrives within a fixed limit, the watchdog drops the interface back to idle and releases SDA. A stuck controller or a glitched line therefore cannot hold the bus forever.

Top module: `i2c_target_wdt`

## Requirements
- R1: After reset, and while the bus stays idle with both lines high, `sda_oe` is 0, `reg_we` is 0 and `reg_addr` is 0.
- R2: A START (SDA falling while SCL is high) begins address reception. The next eight bits, sampled on SCL rising edges, are taken MSB first as a 7-bit address followed by a direction bit.
- R3: A STOP (SDA rising while SCL is high) returns the block to idle with SDA released. Bits clocked after a STOP are ignored until the next START.
- R4: A START seen before a STOP restarts address reception directly. A new write transfer begun that way loads the pointer again from its first data byte.
- R5: The address 0110010 (0x32) is acknowledged by pulling SDA low (`sda_oe`=1) for the ninth clock. Any other address gets no acknowledge, and the block ignores the bus until the next START or STOP.
- R6: With direction bit 0 (write), every byte is acknowledged. The first data byte loads `reg_addr`. Each later byte appears on `reg_wdata` with `reg_we` high for exactly one cycle at the current `reg_addr`, and `reg_addr` then increments by one, wrapping from 0xFF to 0x00.
- R7: With direction bit 1 (read), the byte on `reg_rdata` for the current `reg_addr` is shifted out MSB first, with `sda_oe`=1 for a 0 bit. `reg_addr` increments after each byte sent.
- R8: During a read, a controller acknowledge (SDA low on the ninth clock) continues with the next byte. A not-acknowledge ends output, and SDA stays released until STOP or START.
- R9: If `TIMEOUT_CYC` cycles pass after the most recent START without a STOP, the block returns to idle, releases SDA and ignores bits until a new START. Each START, repeated ones included, restarts the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Byte to write at `reg_addr` |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register contents at `reg_addr`, combinational from the core |

## Verification
The assertions assume a well-formed bus. The controller moves SDA only while SCL is low, except to form START and STOP. Each SCL high and low phase lasts well beyond the synchronizer delay, so the block's own SDA changes land inside the low phase. The assertions also assume `reg_rdata` settles within a few cycles of a pointer change. The bench keeps to these assumptions: it drives the bus in quarter-bit steps of several clocks and changes SDA only in the middle of the low phase. It samples the wired-AND line while SCL is high, and applies random data, pointers and transfer lengths within the watchdog limit. Only the timeout cases deliberately exceed that limit.

// File: rtl/i2c_target_wdt.sv
module i2c_target_wdt #(
  parameter logic [6:0]  DEV_ADDR    = 7'b0110010,
  parameter int unsigned TIMEOUT_CYC = 95_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WBYTE, S_WACK, S_RBYTE, S_RACK, S_SKIP
  } state_t;

  state_t state;
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q, scl_s, sda_s;
  logic start_det, stop_det, scl_rise, scl_fall, tmr_hit;
  logic [TW-1:0] tmr;
  logic [3:0] cnt;
  logic [7:0] sr;
  logic rw, ptr_set, mack;

  assign scl_s     = scl_sh[SYNC_STAGES-1];
  assign sda_s     = sda_sh[SYNC_STAGES-1];
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign tmr_hit   = (state != S_IDLE) && (tmr == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          tmr <= '0;
    else if (start_det || state == S_IDLE) tmr <= '0;
    else if (!tmr_hit)                   tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      sr        <= '0;
      rw        <= 1'b0;
      ptr_set   <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we) reg_addr <= reg_addr + 1'b1;
      if (start_det) begin
        state   <= S_ADDR;
        cnt     <= '0;
        sda_oe  <= 1'b0;
        ptr_set <= 1'b0;
      end else if (stop_det || tmr_hit) begin
        state  <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_WBYTE: begin
            if (scl_rise && cnt != 4'd8) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (state == S_ADDR) begin
                if (sr[7:1] == DEV_ADDR) begin
                  state  <= S_AACK;
                  sda_oe <= 1'b1;
                  rw     <= sr[0];
                end else begin
                  state <= S_SKIP;
                end
              end else begin
                state   <= S_WACK;
                sda_oe  <= 1'b1;
                ptr_set <= 1'b1;
                if (!ptr_set) begin
                  reg_addr <= sr;
                end else begin
                  reg_we    <= 1'b1;
                  reg_wdata <= sr;
                end
              end
            end
          end
          S_AACK, S_WACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (state == S_AACK && rw) begin
                state  <= S_RBYTE;
                sr     <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
              end else begin
                state  <= S_WBYTE;
                sda_oe <= 1'b0;
              end
            end
          end
          S_RBYTE: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                state    <= S_RACK;
                sda_oe   <= 1'b0;
                reg_addr <= reg_addr + 1'b1;
              end else begin
                sr     <= {sr[6:0], 1'b0};
                sda_oe <= ~sr[6];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                state  <= S_RBYTE;
                cnt    <= '0;
                sr     <= reg_rdata;
                sda_oe <= ~reg_rdata[7];
              end else begin
                state <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_target_wdt_chk.sv
module i2c_target_wdt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_det,
  input logic       stop_det,
  input logic       tmr_hit,
  input logic [2:0] state,
  input logic       sda_oe,
  input logic       reg_we,
  input logic [7:0] reg_addr
);
  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_ADDR = 3'd1;
  localparam logic [2:0] ST_SKIP = 3'd7;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !sda_oe); // R1
  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> state == ST_ADDR && !sda_oe); // R2
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> state == ST_IDLE && !sda_oe); // R3
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SKIP |-> !sda_oe); // R5
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_addr == $past(reg_addr) + 8'd1); // R6
  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_hit && !start_det |=> state == ST_IDLE && !sda_oe); // R9
endmodule

bind i2c_target_wdt i2c_target_wdt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
  .tmr_hit(tmr_hit), .state(state), .sda_oe(sda_oe), .reg_we(reg_we),
  .reg_addr(reg_addr)
);

// File: tb/i2c_target_wdt_tb.sv
module i2c_target_wdt_tb;
  localparam int TO = 4000;
  localparam int Q  = 8;
  localparam logic [6:0] DEV = 7'b0110010;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic sda_line;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ptr;
  int errors = 0, checks = 0;

  assign sda_line = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_target_wdt #(.TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  function automatic int mem_diffs();
    int n = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) n++;
    return n;
  endfunction

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b; qw(); scl_m = 1'b1; qw(); seen = sda_line; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(~mack, s);
  endtask

  task automatic wr_txn(input logic [7:0] ptr, input int n, input bit do_stop);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b0}, a); chk("R5 address ack", int'(a), 1);
    send_byte(ptr, a);         chk("R6 pointer ack", int'(a), 1);
    exp_ptr = ptr;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      send_byte(d, a); chk("R6 data ack", int'(a), 1);
      exp_mem[exp_ptr] = d;
      exp_ptr = exp_ptr + 8'd1;
    end
    if (do_stop) bus_stop();
  endtask

  task automatic rd_txn(input int n);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b1}, a); chk("R5 read address ack", int'(a), 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      chk("R7 read data", int'(d), int'(exp_mem[exp_ptr]));
      exp_ptr = exp_ptr + 8'd1;
    end
    bus_stop();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    logic a;
    logic [7:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 7 + 3);
    exp_ptr = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 sda_oe idle", int'(sda_oe), 0);
    chk("R1 reg_we idle", int'(reg_we), 0);
    chk("R1 reg_addr reset", int'(reg_addr), 0);

    // R6: write burst with pointer load and increment
    wr_txn(8'h10, 4, 1);
    chk("R6 memory after write", mem_diffs(), 0);
    chk("R6 pointer after write", int'(reg_addr), int'(exp_ptr));

    // R7 and R8: read burst with controller acks
    wr_txn(8'h10, 0, 1);
    rd_txn(4);
    chk("R7 pointer after read", int'(reg_addr), int'(exp_ptr));

    // R6: pointer wraps past 0xFF
    wr_txn(8'hFE, 3, 1);
    chk("R6 wrap memory", mem_diffs(), 0);
    chk("R6 wrap pointer", int'(reg_addr), 1);

    // R8: not-acknowledge releases SDA
    wr_txn(8'h20, 0, 1);
    bus_start();
    send_byte({DEV, 1'b1}, a); chk("R5 read address ack", int'(a), 1);
    recv_byte(1'b0, d); chk("R8 byte before nack", int'(d), int'(exp_mem[8'h20]));
    recv_byte(1'b0, d); chk("R8 released after nack", int'(d), 8'hFF);
    bus_stop();
    exp_ptr = 8'h21;
    chk("R8 pointer after nack", int'(reg_addr), int'(exp_ptr));

    // R5: wrong address is not acknowledged and the transfer is ignored
    bus_start();
    send_byte({7'h33, 1'b0}, a); chk("R5 wrong address nack", int'(a), 0);
    send_byte(8'h40, a);         chk("R5 ignored byte nack", int'(a), 0);
    send_byte(8'h99, a);         chk("R5 ignored data nack", int'(a), 0);
    bus_stop();
    chk("R5 memory untouched", mem_diffs(), 0);
    chk("R5 pointer untouched", int'(reg_addr), int'(exp_ptr));
    bus_start();
    send_byte({7'h12, 1'b1}, a); chk("R5 wrong read address nack", int'(a), 0);
    recv_byte(1'b1, d);          chk("R5 no data on wrong address", int'(d), 8'hFF);
    bus_stop();

    // R4: repeated START chain, write, re-point, read
    wr_txn(8'h30, 2, 0);
    wr_txn(8'h50, 0, 0);
    rd_txn(2);
    chk("R4 memory after repeated start", mem_diffs(), 0);
    chk("R4 pointer after repeated start", int'(reg_addr), 8'h52);

    // R3: bits after STOP are ignored
    wr_txn(8'h60, 1, 1);
    chk("R3 released after stop", int'(sda_oe), 0);
    send_byte({DEV, 1'b0}, a); chk("R3 no ack without start", int'(a), 0);
    send_byte(8'h77, a);       chk("R3 no ack on later byte", int'(a), 0);
    chk("R3 memory untouched", mem_diffs(), 0);

    // R9: acknowledge held past the limit is released
    bus_start();
    for (int i = 7; i >= 0; i--) begin
      logic s;
      clk_bit(i == 0 ? 1'b0 : DEV[i-1], s);
    end
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
    chk("R9 ack before timeout", int'(sda_line), 0);
    repeat (TO) @(negedge clk);
    chk("R9 released after timeout", int'(sda_line), 1);
    scl_m = 1'b0; qw();
    send_byte(8'h70, a); chk("R9 ignored after timeout", int'(a), 0);
    send_byte(8'h71, a); chk("R9 still ignored", int'(a), 0);
    bus_stop();
    chk("R9 memory untouched", mem_diffs(), 0);

    // R9: each START restarts the count
    bus_start();
    send_byte({DEV, 1'b0}, a); chk("R9 first address ack", int'(a), 1);
    repeat (TO * 6 / 10) @(negedge clk);
    bus_start();
    send_byte({DEV, 1'b0}, a); chk("R9 address after restart", int'(a), 1);
    repeat (TO * 6 / 10) @(negedge clk);
    send_byte(8'h80, a); chk("R9 count restarted on START", int'(a), 1);
    bus_stop();
    exp_ptr = 8'h80;
    chk("R9 pointer loaded", int'(reg_addr), int'(exp_ptr));

    // Random traffic
    for (int t = 0; t < 24; t++) begin
      int kind = int'($urandom % 3);
      if (kind == 0) begin
        wr_txn(8'($urandom), 1 + int'($urandom % 6), 1);
      end else if (kind == 1) begin
        rd_txn(1 + int'($urandom % 6));
      end else begin
        wr_txn(8'($urandom), 0, 1);
        rd_txn(1 + int'($urandom % 6));
      end
      chk("R6 random memory", mem_diffs(), 0);
      chk("R7 random pointer", int'(reg_addr), int'(exp_ptr));
    end

    repeat (20) @(negedge clk);
    chk("R1 idle after traffic", int'(sda_oe), 0);
    finish_run();
  end
endmodule